// File: doc/BRIEF.md
# Protected Flash Command Sequence Decoder

This block is the write-side command interpreter of a byte-wide flash memory model. All bus strobes are sampled on the system clock. A write is qualified only when chip enable and write enable are low and output enable is high for at least `MIN_W` consecutive clock cycles. The write is taken when that qualified window closes. Each qualified write is matched against the expected step of an unlock sequence.

Changing the array requires a guard sequence:
- **Byte program:** three unlock writes, then a data write that carries the target address and byte.
- **Erase:** six writes, ending either in a sector-erase or a chip-erase command.

When a sequence completes, the block raises a single-cycle request toward the array and busy-timer logic, which lie outside this block. While busy is high, every write is ignored.

A separate identification mode replaces read data with a manufacturer code and a device code. It is entered and left through short command sequences.

The sequencer states and the transitions on a qualified write (with busy low) are:
- **ST_IDLE**
  - 0xAA at 0x5555 → ST_UNL1.
  - Anything else: stay in ST_IDLE.
- **ST_UNL1**
  - 0x55 at 0x2AAA → ST_UNL2.
  - Anything else → ST_IDLE.
- **ST_UNL2** (command byte, all at 0x5555)
  - 0xA0 → ST_PGM_DATA.
  - 0x80 → ST_ERS_ARM.
  - 0x90 → ST_IDLE, and identification mode is set.
  - 0xF0 → ST_IDLE, and identification mode is cleared.
  - Anything else → ST_IDLE.
- **ST_PGM_DATA**
  - Any write issues a program request → ST_IDLE.
- **ST_ERS_ARM**
  - 0xAA at 0x5555 → ST_ERS_UNL1.
  - Anything else → ST_IDLE.
- **ST_ERS_UNL1**
  - 0x55 at 0x2AAA → ST_ERS_UNL2.
  - Anything else → ST_IDLE.
- **ST_ERS_UNL2**
  - 0x30 at any address issues a sector erase → ST_IDLE.
  - 0x10 at 0x5555 issues a chip erase → ST_IDLE.
  - Anything else → ST_IDLE.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset all request outputs are 0, `id_mode` is 0 and `id_rdata` is 0x00.
- R2: 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 followed by a write of D at A gives one `prog_req` pulse with `req_addr`=A and `req_data`=D, two clock edges after that write's strobe closes.
- R3: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, then 0x30 at address S gives one `sec_erase_req` pulse with `req_addr`=S.
- R4: The same five-write prefix followed by 0x10@0x5555 gives one `chip_erase_req` pulse with `req_addr`=0x5555.
- R5: A write that does not match the expected step returns the decoder to ST_IDLE, so no request follows; a later complete sequence is accepted normally.
- R6: After 0xAA@0x5555, 0x55@0x2AAA, 0x90@0x5555, `id_mode` is 1 and `id_rdata` is 0xBF at address 0, `DEV_CODE` at address 1 and 0x00 elsewhere.
- R7: After 0xAA@0x5555, 0x55@0x2AAA, 0xF0@0x5555, `id_mode` is 0 and `id_rdata` is 0x00 at every address.
- R8: While `busy` is 1, writes have no effect: an exit sequence leaves `id_mode` set and a program sequence issues no request.
- R9: A strobe held for fewer than `MIN_W` clock edges is not a write: inserted into a sequence, it neither aborts the sequence nor serves as its data.
- R10: A strobe with output enable low or chip enable high is not a write and does not disturb a sequence in progress.
- R11: At most one request output is high in any cycle, and each request lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address |
| din | input | 8 | Write data |
| busy | input | 1 | Internal program/erase operation in progress |
| prog_req | output | 1 | Byte-program request pulse |
| sec_erase_req | output | 1 | Sector-erase request pulse |
| chip_erase_req | output | 1 | Chip-erase request pulse |
| req_addr | output | AW | Address that goes with a request |
| req_data | output | 8 | Data byte that goes with a program request |
| id_mode | output | 1 | Identification read mode active |
| id_rdata | output | 8 | Identification read data for `addr` |

## Verification
The bench builds the block with `MIN_W`=3, so a two-cycle strobe lies just below the threshold and a three-cycle strobe just at it; the boundary between ignored and accepted writes is exercised inside live sequences. `DEV_CODE` is set to 0xB6, not the default, so a device code wired to a constant would be exposed. The address width stays at 19 bits, so sector addresses above the 15 compared bits reach `req_addr` intact.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    // Width of the address slice compared against the unlock addresses
    localparam int CMP_W = 15;

    localparam logic [CMP_W-1:0] UNLOCK_ADDR_A = 15'h5555;
    localparam logic [CMP_W-1:0] UNLOCK_ADDR_B = 15'h2AAA;

    localparam logic [7:0] KEY_FIRST   = 8'hAA;
    localparam logic [7:0] KEY_SECOND  = 8'h55;
    localparam logic [7:0] CMD_PROGRAM = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_ID_IN   = 8'h90;
    localparam logic [7:0] CMD_ID_OUT  = 8'hF0;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_CHIP    = 8'h10;

    localparam logic [7:0] MFR_CODE = 8'hBF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_DATA,
        ST_ERS_ARM,
        ST_ERS_UNL1,
        ST_ERS_UNL2
    } seq_state_t;

endpackage

// File: rtl/flash_wr_qual.sv
module flash_wr_qual #(
    parameter int AW    = 19,
    parameter int MIN_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    localparam int CW = $clog2(MIN_W + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(MIN_W);

    logic          active;
    logic [CW-1:0] low_cnt;

    assign active = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            // a window that closes after enough cycles becomes one write
            wr_stb <= !active && (low_cnt >= CNT_MAX);
            if (active) begin
                if (low_cnt != CNT_MAX) begin
                    low_cnt <= low_cnt + 1'b1;
                end
                wr_addr <= addr;
                wr_data <= din;
            end else begin
                low_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          busy,
    output logic          prog_req,
    output logic          sec_erase_req,
    output logic          chip_erase_req,
    output logic [AW-1:0] req_addr,
    output logic [7:0]    req_data,
    output logic          id_mode
);
    seq_state_t state, state_nxt;
    logic go_prog, go_sec, go_chip, id_nxt;
    logic at_a, at_b;

    assign at_a = (wr_addr[CMP_W-1:0] == UNLOCK_ADDR_A);
    assign at_b = (wr_addr[CMP_W-1:0] == UNLOCK_ADDR_B);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        go_prog   = 1'b0;
        go_sec    = 1'b0;
        go_chip   = 1'b0;
        id_nxt    = id_mode;
        if (wr_stb && !busy) begin
            unique case (state)
                ST_IDLE:
                    state_nxt = (at_a && wr_data == KEY_FIRST) ? ST_UNL1 : ST_IDLE;
                ST_UNL1:
                    state_nxt = (at_b && wr_data == KEY_SECOND) ? ST_UNL2 : ST_IDLE;
                ST_UNL2: begin
                    state_nxt = ST_IDLE;
                    if (at_a) begin
                        case (wr_data)
                            CMD_PROGRAM: state_nxt = ST_PGM_DATA;
                            CMD_ERASE:   state_nxt = ST_ERS_ARM;
                            CMD_ID_IN:   id_nxt    = 1'b1;
                            CMD_ID_OUT:  id_nxt    = 1'b0;
                            default:     state_nxt = ST_IDLE;
                        endcase
                    end
                end
                ST_PGM_DATA: begin
                    go_prog   = 1'b1;
                    state_nxt = ST_IDLE;
                end
                ST_ERS_ARM:
                    state_nxt = (at_a && wr_data == KEY_FIRST) ? ST_ERS_UNL1 : ST_IDLE;
                ST_ERS_UNL1:
                    state_nxt = (at_b && wr_data == KEY_SECOND) ? ST_ERS_UNL2 : ST_IDLE;
                ST_ERS_UNL2: begin
                    state_nxt = ST_IDLE;
                    if (wr_data == CMD_SECTOR) begin
                        go_sec = 1'b1;
                    end else if (at_a && wr_data == CMD_CHIP) begin
                        go_chip = 1'b1;
                    end
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_req       <= 1'b0;
            sec_erase_req  <= 1'b0;
            chip_erase_req <= 1'b0;
            req_addr       <= '0;
            req_data       <= '0;
            id_mode        <= 1'b0;
        end else begin
            prog_req       <= go_prog;
            sec_erase_req  <= go_sec;
            chip_erase_req <= go_chip;
            id_mode        <= id_nxt;
            if (go_prog || go_sec || go_chip) begin
                req_addr <= wr_addr;
                req_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom
    import flash_cmd_pkg::*;
#(
    parameter int         AW       = 19,
    parameter logic [7:0] DEV_CODE = 8'hB7
) (
    input  logic          id_mode,
    input  logic [AW-1:0] addr,
    output logic [7:0]    id_rdata
);
    always_comb begin
        id_rdata = 8'h00;
        if (id_mode) begin
            if (addr == AW'(0)) begin
                id_rdata = MFR_CODE;
            end else if (addr == AW'(1)) begin
                id_rdata = DEV_CODE;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int         AW       = 19,
    parameter int         MIN_W    = 2,
    parameter logic [7:0] DEV_CODE = 8'hB7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    input  logic          busy,
    output logic          prog_req,
    output logic          sec_erase_req,
    output logic          chip_erase_req,
    output logic [AW-1:0] req_addr,
    output logic [7:0]    req_data,
    output logic          id_mode,
    output logic [7:0]    id_rdata
);
    logic          wr_stb;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    flash_wr_qual #(.AW(AW), .MIN_W(MIN_W)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .din     (din),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    flash_seq_fsm #(.AW(AW)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_stb         (wr_stb),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .busy           (busy),
        .prog_req       (prog_req),
        .sec_erase_req  (sec_erase_req),
        .chip_erase_req (chip_erase_req),
        .req_addr       (req_addr),
        .req_data       (req_data),
        .id_mode        (id_mode)
    );

    flash_id_rom #(.AW(AW), .DEV_CODE(DEV_CODE)) u_rom (
        .id_mode  (id_mode),
        .addr     (addr),
        .id_rdata (id_rdata)
    );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int         AW       = 19,
    parameter logic [7:0] DEV_CODE = 8'hB7
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          busy,
    input logic          prog_req,
    input logic          sec_erase_req,
    input logic          chip_erase_req,
    input logic          id_mode,
    input logic [7:0]    id_rdata
);
    a_r11_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_req, sec_erase_req, chip_erase_req}));

    a_r11_prog_single: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);

    a_r11_erase_single: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_erase_req || chip_erase_req) |=> !(sec_erase_req || chip_erase_req));

    a_r8_busy_keeps_id: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(id_mode));

    a_r8_busy_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !(prog_req || sec_erase_req || chip_erase_req));

    a_r6_mfr_code: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && addr == AW'(0)) |-> id_rdata == 8'hBF);

    a_r6_dev_code: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && addr == AW'(1)) |-> id_rdata == DEV_CODE);

    a_r7_read_mode_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !id_mode |-> id_rdata == 8'h00);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.AW(AW), .DEV_CODE(DEV_CODE)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .addr           (addr),
    .busy           (busy),
    .prog_req       (prog_req),
    .sec_erase_req  (sec_erase_req),
    .chip_erase_req (chip_erase_req),
    .id_mode        (id_mode),
    .id_rdata       (id_rdata)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
    localparam int         AW    = 19;
    localparam int         MIN_W = 3;
    localparam logic [7:0] DEV   = 8'hB6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, busy = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din  = '0;
    logic prog_req, sec_erase_req, chip_erase_req, id_mode;
    logic [AW-1:0] req_addr;
    logic [7:0]    req_data, id_rdata;

    flash_cmd_decoder #(.AW(AW), .MIN_W(MIN_W), .DEV_CODE(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .busy(busy),
        .prog_req(prog_req), .sec_erase_req(sec_erase_req),
        .chip_erase_req(chip_erase_req), .req_addr(req_addr),
        .req_data(req_data), .id_mode(id_mode), .id_rdata(id_rdata)
    );

    always #5 clk = ~clk;

    typedef struct {
        int            kind;
        logic [AW-1:0] a;
        logic [7:0]    d;
        string         tag;
    } exp_t;

    exp_t q[$];
    int errors = 0, checks = 0;
    int mk;
    exp_t me;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [AW-1:0] a,
                        input logic [7:0] d, input string tag);
        exp_t e;
        e.kind = kind; e.a = a; e.d = d; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: pops the scoreboard whenever a request appears
    always @(negedge clk) begin
        if (rst_n) begin
            mk = prog_req ? 1 : sec_erase_req ? 2 : chip_erase_req ? 3 : 0;
            if (mk != 0) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected request kind", mk, 0);
                end else begin
                    me = q.pop_front();
                    chk(mk == me.kind, me.tag, "request kind", mk, me.kind);
                    chk(req_addr == me.a, me.tag, "req_addr", req_addr, me.a);
                    if (me.kind == 1)
                        chk(req_data == me.d, me.tag, "req_data", req_data, me.d);
                end
            end
        end
    end

    task automatic wr_q(input logic [AW-1:0] a, input logic [7:0] d,
                        input int len, input logic ce, input logic oe);
        @(negedge clk);
        addr = a; din = d; ce_n = ce; oe_n = oe; we_n = 1'b0;
        repeat (len) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_q(a, d, MIN_W, 1'b0, 1'b1);
    endtask

    task automatic unlock();
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
    endtask

    task automatic settle_empty(input string tag);
        repeat (4) @(negedge clk);
        chk(q.size() == 0, tag, "pending expected requests", q.size(), 0);
    endtask

    task automatic read_id(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        chk(id_rdata == exp, tag, "id_rdata", id_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!prog_req && !sec_erase_req && !chip_erase_req, "R1", "requests", 1, 0);
        chk(id_mode == 1'b0, "R1", "id_mode", id_mode, 0);
        chk(id_rdata == 8'h00, "R1", "id_rdata", id_rdata, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 plain program
        unlock(); wr(19'h05555, 8'hA0);
        push(1, 19'h01234, 8'h5A, "R2");
        wr(19'h01234, 8'h5A);
        settle_empty("R2");

        // R3 sector erase, high address bits carried
        unlock(); wr(19'h05555, 8'h80); unlock();
        push(2, 19'h41000, 8'h30, "R3");
        wr(19'h41000, 8'h30);
        settle_empty("R3");

        // R4 chip erase
        unlock(); wr(19'h05555, 8'h80); unlock();
        push(3, 19'h05555, 8'h10, "R4");
        wr(19'h05555, 8'h10);
        settle_empty("R4");

        // R5 aborts: wrong address on command, wrong key, wrong erase final
        unlock(); wr(19'h02AAA, 8'hA0); wr(19'h00100, 8'h12);
        wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h56); wr(19'h05555, 8'hA0); wr(19'h00101, 8'h13);
        unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h05555, 8'h20);
        settle_empty("R5");
        unlock(); wr(19'h05555, 8'hA0);
        push(1, 19'h00200, 8'hC3, "R5");
        wr(19'h00200, 8'hC3);
        settle_empty("R5");

        // R9 short strobe neither aborts nor acts as data
        unlock(); wr_q(19'h00777, 8'h77, MIN_W - 1, 1'b0, 1'b1);
        wr(19'h05555, 8'hA0);
        wr_q(19'h00300, 8'h77, MIN_W - 1, 1'b0, 1'b1);
        push(1, 19'h00400, 8'h3C, "R9");
        wr(19'h00400, 8'h3C);
        settle_empty("R9");

        // R10 strobes with OE low or CE high are not writes
        unlock(); wr_q(19'h00500, 8'h99, MIN_W, 1'b0, 1'b0);
        wr(19'h05555, 8'hA0);
        wr_q(19'h00501, 8'h98, MIN_W, 1'b1, 1'b1);
        wr_q(19'h00502, 8'h97, MIN_W, 1'b0, 1'b0);
        push(1, 19'h00600, 8'hE1, "R10");
        wr(19'h00600, 8'hE1);
        settle_empty("R10");

        // R6 identification mode
        read_id(19'h00000, 8'h00, "R6");
        unlock(); wr(19'h05555, 8'h90);
        chk(id_mode == 1'b1, "R6", "id_mode", id_mode, 1);
        read_id(19'h00000, 8'hBF, "R6");
        read_id(19'h00001, DEV, "R6");
        read_id(19'h00002, 8'h00, "R6");

        // R8 busy: exit and program are ignored
        @(negedge clk); busy = 1'b1;
        unlock(); wr(19'h05555, 8'hF0);
        unlock(); wr(19'h05555, 8'hA0); wr(19'h00700, 8'h44);
        @(negedge clk); busy = 1'b0;
        chk(id_mode == 1'b1, "R8", "id_mode after busy exit", id_mode, 1);
        read_id(19'h00000, 8'hBF, "R8");
        settle_empty("R8");

        // R7 exit
        unlock(); wr(19'h05555, 8'hF0);
        chk(id_mode == 1'b0, "R7", "id_mode", id_mode, 0);
        read_id(19'h00000, 8'h00, "R7");
        read_id(19'h00001, 8'h00, "R7");

        // R11 back-to-back sequences each give exactly one pulse
        unlock(); wr(19'h05555, 8'hA0);
        push(1, 19'h00010, 8'h01, "R11");
        wr(19'h00010, 8'h01);
        unlock(); wr(19'h05555, 8'hA0);
        push(1, 19'h00011, 8'h02, "R11");
        wr(19'h00011, 8'h02);
        settle_empty("R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule